// File: doc/BRIEF.md
# Banked Interrupt Controller

This block gathers interrupt sources into several identical banks of 32 and presents one request line per bank to a processor. Each bank keeps a pending bit per source, set whenever the source input is high, and an enable bit per source. The enabled pending bits form the bank's masked view. The bank's request line is raised whenever that masked view is non-zero. A combinational priority encoder picks the highest-numbered enabled pending source as the bank's vector.

Software reaches the registers over a simple 32-bit word bus. Each bank owns a window of 0x28 bytes. Inside the window, the pending register is at 0x00, the enable register at 0x08, the masked view at 0x10 and a vector register at 0x18. A source is acknowledged by writing a one to its pending bit. A bus-side state machine has two states. BUS_IDLE moves to BUS_RESP when a read is requested. BUS_RESP stays in BUS_RESP on a back-to-back read and returns to BUS_IDLE otherwise. In BUS_RESP the captured read word is presented with a valid strobe.

Top module: `intc_unit`

## Requirements
- R1: After reset every pending and enable bit is zero, every request line is low and every vector valid flag is low.
- R2: A source input sampled high at a clock edge sets its pending bit at that edge, whatever its enable bit holds. The pending register reads back at bank offset 0x00.
- R3: A write to bank offset 0x00 clears each pending bit whose write-data bit is one. Bits written as zero keep their value.
- R4: A write to bank offset 0x08 loads the enable register, which reads back at 0x08. The masked register at 0x10 reads pending AND enable.
- R5: A bank's request line is high exactly when its masked register is non-zero.
- R6: Each bank outputs a 5-bit index of its highest set masked bit and a valid flag equal to its request line. Offset 0x18 reads the index in bits [4:0] and the valid flag in bit 8.
- R7: When a source is high in the same cycle as a write that clears its pending bit, the bit ends set.
- R8: Bank b's window starts at byte address b*0x28. Writes to one bank leave the registers of every other bank unchanged.
- R9: Reads of unmapped addresses return zero and writes to them change no register. Unmapped addresses are offsets 0x20 and any non-listed offset inside a window, and any address beyond the last bank.
- R10: Read data appears with the valid strobe in the cycle after the read request, and the strobe is low in any cycle that does not follow a read request. The masked and vector registers ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_BANKS*32 | Source inputs; bank b uses bits [b*32 +: 32] |
| bus_sel | input | 1 | Bus access request in this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data strobe, one cycle after a read |
| cpu_req | output | NUM_BANKS | Per-bank request line to the processor |
| vec_idx | output | NUM_BANKS*5 | Per-bank highest masked pending index |
| vec_valid | output | NUM_BANKS | Per-bank vector valid flag |

## Verification
The bench builds the unit with three banks and an 8-bit address. The three banks put the first window at 0x00, an interior window at 0x28 and the last window at 0x50. The address 0x78 sits just past the last window, so cross-bank isolation and the out-of-range decode can both be observed. Source bits 0 and 31 are driven in separate banks to reach both ends of the priority encoder. A source held high across a clearing write exercises the set-over-clear rule.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int SRC_W       = 32;
    localparam int IDX_W       = 5;
    localparam int BANK_STRIDE = 40;   // 0x28 bytes per bank window

    localparam int OFF_PEND    = 0;    // 0x00
    localparam int OFF_EN      = 8;    // 0x08
    localparam int OFF_MASKED  = 16;   // 0x10
    localparam int OFF_VEC     = 24;   // 0x18

    localparam int VEC_VALID_BIT = 8;

    typedef enum logic [0:0] {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_st_e;

endpackage

// File: rtl/intc_prio.sv
module intc_prio #(
    parameter int W  = 32,
    parameter int IW = 5
) (
    input  logic [W-1:0]  bits_i,
    output logic [IW-1:0] idx_o,
    output logic          valid_o
);

    // Scan upward; the last set bit seen is the highest one.
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < W; i++) begin
            if (bits_i[i]) begin
                idx_o = IW'(i);
            end
        end
    end

    assign valid_o = |bits_i;

endmodule

// File: rtl/intc_bank.sv
module intc_bank
    import intc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] src_i,
    input  logic [SRC_W-1:0] clr_i,
    input  logic             en_we_i,
    input  logic [SRC_W-1:0] en_wdata_i,
    output logic [SRC_W-1:0] pend_o,
    output logic [SRC_W-1:0] en_o,
    output logic [SRC_W-1:0] masked_o,
    output logic             req_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             valid_o
);

    logic [SRC_W-1:0] pend_q;
    logic [SRC_W-1:0] en_q;

    // Pending: clear first, then set, so a live source wins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_i) | src_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (en_we_i) begin
            en_q <= en_wdata_i;
        end
    end

    assign masked_o = pend_q & en_q;
    assign req_o    = |masked_o;
    assign pend_o   = pend_q;
    assign en_o     = en_q;

    intc_prio #(
        .W  (SRC_W),
        .IW (IDX_W)
    ) prio_i (
        .bits_i  (masked_o),
        .idx_o   (idx_o),
        .valid_o (valid_o)
    );

endmodule

// File: rtl/intc_regdec.sv
module intc_regdec
    import intc_pkg::*;
#(
    parameter int NUM_BANKS = 5,
    parameter int ADDR_W    = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                bus_sel,
    input  logic                                bus_wr,
    input  logic [ADDR_W-1:0]                   bus_addr,
    input  logic [31:0]                         bus_wdata,
    input  logic [NUM_BANKS-1:0][SRC_W-1:0]     pend_i,
    input  logic [NUM_BANKS-1:0][SRC_W-1:0]     en_i,
    input  logic [NUM_BANKS-1:0][SRC_W-1:0]     masked_i,
    input  logic [NUM_BANKS-1:0][SRC_W-1:0]     vec_i,
    output logic [NUM_BANKS-1:0][SRC_W-1:0]     clr_o,
    output logic [NUM_BANKS-1:0]                en_we_o,
    output logic [31:0]                         bus_rdata,
    output logic                                bus_rvalid
);

    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    bus_st_e            state_q;
    bus_st_e            state_d;
    logic               hit;
    logic [BANK_W-1:0]  bank_sel;
    logic [ADDR_W-1:0]  off;
    logic [31:0]        rd_word;
    logic [31:0]        rdata_q;
    logic               rd_req;
    logic               wr_req;

    assign rd_req = bus_sel && !bus_wr;
    assign wr_req = bus_sel &&  bus_wr;

    // Window decode: which bank, and the offset inside it.
    always_comb begin
        hit      = 1'b0;
        bank_sel = '0;
        off      = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (int'(bus_addr) >= b * BANK_STRIDE &&
                int'(bus_addr) < (b + 1) * BANK_STRIDE) begin
                hit      = 1'b1;
                bank_sel = BANK_W'(b);
                off      = bus_addr - ADDR_W'(b * BANK_STRIDE);
            end
        end
    end

    // Read mux; unlisted offsets fall through to zero.
    always_comb begin
        rd_word = '0;
        if (hit) begin
            if (off == ADDR_W'(OFF_PEND)) begin
                rd_word = pend_i[bank_sel];
            end else if (off == ADDR_W'(OFF_EN)) begin
                rd_word = en_i[bank_sel];
            end else if (off == ADDR_W'(OFF_MASKED)) begin
                rd_word = masked_i[bank_sel];
            end else if (off == ADDR_W'(OFF_VEC)) begin
                rd_word = vec_i[bank_sel];
            end
        end
    end

    // Write strobes per bank.
    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            clr_o[b]   = '0;
            en_we_o[b] = 1'b0;
            if (wr_req && hit && bank_sel == BANK_W'(b)) begin
                if (off == ADDR_W'(OFF_PEND)) begin
                    clr_o[b] = bus_wdata;
                end
                if (off == ADDR_W'(OFF_EN)) begin
                    en_we_o[b] = 1'b1;
                end
            end
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (rd_req) state_d = BUS_RESP;
            BUS_RESP: state_d = rd_req ? BUS_RESP : BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    // Outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rd_req ? rd_word : '0;
        end
    end

    assign bus_rdata  = rdata_q;
    assign bus_rvalid = (state_q == BUS_RESP);

endmodule

// File: rtl/intc_unit.sv
module intc_unit
    import intc_pkg::*;
#(
    parameter int NUM_BANKS = 5,
    parameter int ADDR_W    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_BANKS*SRC_W-1:0] src_i,
    input  logic                       bus_sel,
    input  logic                       bus_wr,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [31:0]                bus_wdata,
    output logic [31:0]                bus_rdata,
    output logic                       bus_rvalid,
    output logic [NUM_BANKS-1:0]       cpu_req,
    output logic [NUM_BANKS*IDX_W-1:0] vec_idx,
    output logic [NUM_BANKS-1:0]       vec_valid
);

    logic [NUM_BANKS-1:0][SRC_W-1:0] pend_arr;
    logic [NUM_BANKS-1:0][SRC_W-1:0] en_arr;
    logic [NUM_BANKS-1:0][SRC_W-1:0] masked_arr;
    logic [NUM_BANKS-1:0][SRC_W-1:0] vec_arr;
    logic [NUM_BANKS-1:0][SRC_W-1:0] clr_arr;
    logic [NUM_BANKS-1:0]            en_we;
    logic [NUM_BANKS*SRC_W-1:0]      pend_flat;
    logic [NUM_BANKS*SRC_W-1:0]      masked_flat;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [IDX_W-1:0] idx;
        logic             vld;

        intc_bank bank_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .src_i      (src_i[b*SRC_W +: SRC_W]),
            .clr_i      (clr_arr[b]),
            .en_we_i    (en_we[b]),
            .en_wdata_i (bus_wdata),
            .pend_o     (pend_arr[b]),
            .en_o       (en_arr[b]),
            .masked_o   (masked_arr[b]),
            .req_o      (cpu_req[b]),
            .idx_o      (idx),
            .valid_o    (vld)
        );

        assign vec_idx[b*IDX_W +: IDX_W] = idx;
        assign vec_valid[b]              = vld;
        assign vec_arr[b] = {{(SRC_W-VEC_VALID_BIT-1){1'b0}}, vld,
                             {(VEC_VALID_BIT-IDX_W){1'b0}}, idx};
        assign pend_flat[b*SRC_W +: SRC_W]   = pend_arr[b];
        assign masked_flat[b*SRC_W +: SRC_W] = masked_arr[b];
    end

    intc_regdec #(
        .NUM_BANKS (NUM_BANKS),
        .ADDR_W    (ADDR_W)
    ) dec_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .pend_i     (pend_arr),
        .en_i       (en_arr),
        .masked_i   (masked_arr),
        .vec_i      (vec_arr),
        .clr_o      (clr_arr),
        .en_we_o    (en_we),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid)
    );

endmodule

// File: rtl/intc_unit_chk.sv
module intc_unit_chk
    import intc_pkg::*;
#(
    parameter int NUM_BANKS = 5
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_sel,
    input logic                       bus_wr,
    input logic                       bus_rvalid,
    input logic [NUM_BANKS-1:0]       cpu_req,
    input logic [NUM_BANKS-1:0]       vec_valid,
    input logic [NUM_BANKS*IDX_W-1:0] vec_idx,
    input logic [NUM_BANKS*SRC_W-1:0] src_i,
    input logic [NUM_BANKS*SRC_W-1:0] pend_flat,
    input logic [NUM_BANKS*SRC_W-1:0] masked_flat
);

    // R10: a read request is answered in the next cycle.
    a_r10_read_resp: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr) |=> bus_rvalid);

    // R10: no strobe without a preceding read request.
    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> !bus_rvalid);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
        // R6: encoder valid agrees with the bank request OR.
        a_r6_valid_eq_req: assert property (@(posedge clk) disable iff (!rst_n)
            vec_valid[b] == cpu_req[b]);

        // R6: index names the top set masked bit.
        a_r6_idx_is_top: assert property (@(posedge clk) disable iff (!rst_n)
            vec_valid[b] |->
                ((masked_flat[b*SRC_W +: SRC_W] >> vec_idx[b*IDX_W +: IDX_W]) == 32'd1));

        // R7 / R2: a live source always leaves its pending bit set.
        a_r7_src_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (|src_i[b*SRC_W +: SRC_W]) |=>
                ((pend_flat[b*SRC_W +: SRC_W] & $past(src_i[b*SRC_W +: SRC_W]))
                 == $past(src_i[b*SRC_W +: SRC_W])));
    end

endmodule

bind intc_unit intc_unit_chk #(
    .NUM_BANKS (NUM_BANKS)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_rvalid  (bus_rvalid),
    .cpu_req     (cpu_req),
    .vec_valid   (vec_valid),
    .vec_idx     (vec_idx),
    .src_i       (src_i),
    .pend_flat   (pend_flat),
    .masked_flat (masked_flat)
);

// File: tb/intc_unit_tb.sv
module intc_unit_tb_top;

    localparam int NB = 3;
    localparam int AW = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NB*32-1:0]  src_i = '0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [AW-1:0]     bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_rvalid;
    logic [NB-1:0]     cpu_req;
    logic [NB*5-1:0]   vec_idx;
    logic [NB-1:0]     vec_valid;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    intc_unit #(.NUM_BANKS(NB), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_i(src_i),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .cpu_req(cpu_req), .vec_idx(vec_idx), .vec_valid(vec_valid)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        check("R10 rvalid after read", 32'(bus_rvalid), 32'd1);
        d = bus_rdata;
    endtask

    task automatic pulse_src(input logic [NB*32-1:0] m);
        @(negedge clk);
        src_i = m;
        @(negedge clk);
        src_i = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 req low", 32'(cpu_req), 32'd0);
        check("R1 vec_valid low", 32'(vec_valid), 32'd0);
        bus_read(8'h00, d); check("R1 pend zero", d, 32'd0);
        bus_read(8'h08, d); check("R1 en zero", d, 32'd0);
        @(negedge clk);
        check("R10 rvalid drops", 32'(bus_rvalid), 32'd0);
    endtask

    task automatic t_raw_set();
        logic [31:0] d;
        pulse_src(96'h0000_0000_0000_0000_0002_0008);
        bus_read(8'h00, d); check("R2 pend set while disabled", d, 32'h0002_0008);
        check("R5 no req while disabled", 32'(cpu_req), 32'd0);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        bus_write(8'h08, 32'h0000_0008);
        bus_read(8'h08, d);  check("R4 en readback", d, 32'h0000_0008);
        bus_read(8'h10, d);  check("R4 masked", d, 32'h0000_0008);
        check("R5 req bank0", 32'(cpu_req), 32'b001);
        check("R6 idx 3", 32'(vec_idx[4:0]), 32'd3);
        bus_write(8'h08, 32'h0002_0008);
        check("R6 idx 17", 32'(vec_idx[4:0]), 32'd17);
        bus_read(8'h18, d);  check("R6 vector word", d, 32'h0000_0111);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        bus_write(8'h00, 32'h0000_0000);
        bus_read(8'h00, d); check("R3 zero write keeps", d, 32'h0002_0008);
        bus_write(8'h00, 32'h0002_0000);
        bus_read(8'h00, d); check("R3 clear bit17", d, 32'h0000_0008);
        check("R6 idx back to 3", 32'(vec_idx[4:0]), 32'd3);
    endtask

    task automatic t_set_wins();
        logic [31:0] d;
        @(negedge clk);
        src_i = 96'h8; bus_sel = 1'b1; bus_wr = 1'b1;
        bus_addr = 8'h00; bus_wdata = 32'h0000_0008;
        @(negedge clk);
        src_i = '0; bus_sel = 1'b0; bus_wr = 1'b0;
        bus_read(8'h00, d); check("R7 set beats clear", d, 32'h0000_0008);
        bus_write(8'h00, 32'hFFFF_FFFF);
        bus_read(8'h00, d); check("R3 clear all", d, 32'h0);
        check("R5 req drops", 32'(cpu_req), 32'd0);
        check("R6 valid drops", 32'(vec_valid), 32'd0);
    endtask

    task automatic t_stride();
        logic [31:0] d;
        pulse_src({32'h0000_0001, 32'h8000_0000, 32'h0});
        bus_write(8'h30, 32'hFFFF_FFFF);
        bus_read(8'h28, d); check("R8 bank1 pend", d, 32'h8000_0000);
        bus_read(8'h50, d); check("R8 bank2 pend", d, 32'h0000_0001);
        bus_read(8'h08, d); check("R8 bank0 en untouched", d, 32'h0002_0008);
        check("R8 only bank1 requests", 32'(cpu_req), 32'b010);
        check("R6 bank1 idx 31", 32'(vec_idx[9:5]), 32'd31);
        bus_write(8'h58, 32'h0000_0001);
        check("R6 bank2 idx 0", 32'(vec_idx[14:10]), 32'd0);
        check("R8 bank2 requests", 32'(cpu_req), 32'b110);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        bus_write(8'h20, 32'hFFFF_FFFF);
        bus_write(8'h04, 32'hFFFF_FFFF);
        bus_write(8'h78, 32'hFFFF_FFFF);
        bus_read(8'h20, d); check("R9 0x20 reads zero", d, 32'h0);
        bus_read(8'h78, d); check("R9 past last bank zero", d, 32'h0);
        bus_read(8'h04, d); check("R9 gap reads zero", d, 32'h0);
        bus_read(8'h08, d); check("R9 en unchanged", d, 32'h0002_0008);
        bus_write(8'h10, 32'hFFFF_FFFF);
        bus_write(8'h18, 32'hFFFF_FFFF);
        bus_read(8'h10, d); check("R10 masked read-only", d, 32'h0);
        bus_read(8'h08, d); check("R10 en not hit by masked write", d, 32'h0002_0008);
        bus_read(8'h00, d); check("R10 pend not hit by masked write", d, 32'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_raw_set();
        t_enable();
        t_w1c();
        t_set_wins();
        t_stride();
        t_unmapped();
        finish_run();
    end

endmodule